// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the target (slave) side of a two-wire I2C bus with a 7-bit address. The SCL and SDA pads are open-drain. The block reads both lines through a short synchronizer and pulls a line low by raising its drive-low enable. It detects START and STOP, shifts in the address byte and compares it with a fixed device address. It then receives or transmits data bytes one at a time through a single byte buffer. A local controller works the block through plain strobes. It can read the buffer, write a transmit byte, clear the interrupt and overflow flags, and release a stretched clock.

On a master write the block acknowledges each accepted byte and stores it in the buffer. If stretching is enabled, it holds SCL low after each data byte until the controller releases the clock. On a master read it always holds SCL after the address acknowledge. The controller then loads a byte and releases the clock, and the block shifts the byte out. The master's acknowledge decides between a new hold and a return to idle.

Top module: `i2c_tgt_engine`

## Requirements
- R1: After reset, both drive-low enables are 0 and `irq`, `buf_full`, `ovf` and `dir_read` are 0. `buf_rdata` is 0x00.
- R2: When an address byte matches (bits 7:1 equal `DEV_ADDR`) and bit 0 is 0, the block pulls SDA low during the ninth clock. The whole address byte goes into the buffer, `dir_read` goes to 0 and `buf_full` goes to 1. Each later data byte that is accepted is acknowledged and stored in the same way.
- R3: When the address byte does not match, the block gives no acknowledge and raises no interrupt. It then ignores all traffic until the next START, so the buffer keeps its contents.
- R4: A byte that arrives while `buf_full` or `ovf` is 1 is not acknowledged and the buffer keeps its old value. The engine goes back to idle. If `buf_full` was 1, `ovf` is set. `ovf_clr` clears `ovf`.
- R5: `irq` is set for every transferred byte and stays at 1 until `irq_clr` is pulsed. `buf_full` stays at 1 until `buf_rd` is pulsed.
- R6: With `stretch_en` at 1, SCL is held low after the ninth clock of each received data byte until `clk_release` is pulsed. An address byte for a write is never stretched, and with `stretch_en` at 0 no write byte is stretched.
- R7: When the address matches and bit 0 is 1, the block acknowledges, stores the address byte and sets `dir_read` to 1. It then holds SCL low after the ninth clock, whatever the value of `stretch_en`.
- R8: `buf_wr` loads both the buffer and the transmit shift register. After `clk_release`, the byte is sent MSB first, and SDA changes only while SCL is low.
- R9: The master's acknowledge is sampled at the rising edge of the ninth clock of a transmitted byte, and `irq` is set at the falling edge of that clock. On an ACK (SDA low), SCL is held low again. On a NACK (SDA high), SCL is released, `dir_read` goes to 0 and the engine waits for a new START.
- R10: A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) ends any transfer at any time and releases both lines. After a START the engine receives an address byte. After a STOP it ignores traffic until a new START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or data 0) |
| stretch_en | input | 1 | Stretch after each received data byte |
| clk_release | input | 1 | Pulse: let SCL go |
| buf_wr | input | 1 | Pulse: write buffer and transmit shifter |
| buf_wdata | input | 8 | Byte for `buf_wr` |
| buf_rd | input | 1 | Pulse: buffer has been read, clears `buf_full` |
| buf_rdata | output | 8 | Buffer contents |
| irq_clr | input | 1 | Pulse: clear `irq` |
| ovf_clr | input | 1 | Pulse: clear `ovf` |
| irq | output | 1 | Byte-transferred interrupt flag |
| buf_full | output | 1 | Buffer holds an unread received byte |
| ovf | output | 1 | A byte arrived while the buffer was full |
| dir_read | output | 1 | Last matched address asked for a read |

## Verification
The bench builds the engine with `DEV_ADDR` = 7'h5C and `SYNC_STAGES` = 3. The device address sets bit 6 and clears bit 0, so a mismatch in a single high or low address bit is caught. The deeper synchronizer moves every pin reaction one cycle later than the default does. The bus model runs eight system clocks per quarter bit, so acknowledges and stretch holds are still seen inside the bit window. The master waits on the wired SCL level, which makes every stretch visible as a delayed rising edge.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
// i2c_tgt_pkg: constants and shared types for the I2C target engine.
// Assumes byte-wide transfers and a 7-bit address.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_RX,
        PH_TX
    } phase_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
// i2c_tgt_sync: brings SCL and SDA into the clock domain and flags
// SCL edges and START/STOP conditions one cycle after the last stage.
// Assumes STAGES >= 1 and idle-high lines at reset.
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     scl_s,
    output logic     sda_s,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chain for both pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
            for (int k = 1; k < STAGES; k++) begin
                scl_ff[k] <= scl_ff[k-1];
                sda_ff[k] <= sda_ff[k-1];
            end
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
`timescale 1ns/1ps
// i2c_tgt_ctrl: bit-level protocol engine. Counts SCL pulses, shifts
// receive and transmit bytes, decides the acknowledge and drives the
// SDA/SCL pull-downs. Line changes happen only on synchronized SCL
// falling edges, or while SCL is held low by this block.
// Assumes the register side applies the flag updates it requests.
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  bus_evt_t          evt,
    input  logic              stretch_en,
    input  logic              clk_release,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_full,
    input  logic              ovf_flag,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ovf_set,
    output logic              irq_set,
    output logic              dir_set,
    output logic              dir_clr
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              mack;
    logic              is_rx;
    logic              addressed;
    logic              accept;
    logic              byte_end;
    logic              tx_end;

    // Decode of the byte-boundary decisions.
    assign is_rx     = (phase == PH_ADDR) || (phase == PH_RX);
    assign addressed = (phase == PH_RX) || (rx_sh[BYTE_W-1:1] == DEV_ADDR);
    assign accept    = addressed && !buf_full && !ovf_flag;
    assign byte_end  = is_rx && evt.fall && (cnt == CNT_FULL);
    assign tx_end    = (phase == PH_TX) && evt.fall && (cnt == CNT_ACK);

    // Requests to the register side.
    assign rx_load = byte_end && accept;
    assign rx_byte = rx_sh;
    assign ovf_set = byte_end && addressed && buf_full;
    assign irq_set = rx_load || tx_end;
    assign dir_set = rx_load && (phase == PH_ADDR) && rx_sh[0];
    assign dir_clr = (rx_load && (phase == PH_ADDR) && !rx_sh[0])
                   || (tx_end && !mack) || evt.stop;

    // Phase, bit counter, shifters and pin drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else if (evt.start) begin
            phase  <= PH_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else if (evt.stop) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else begin
            if (clk_release) begin
                scl_oe <= 1'b0;
            end
            if (buf_wr && (phase == PH_TX) && (cnt == '0)) begin
                tx_sh  <= buf_wdata;
                sda_oe <= ~buf_wdata[BYTE_W-1];
            end
            case (phase)
                PH_ADDR, PH_RX: begin
                    if (evt.rise && (cnt < CNT_FULL)) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_end) begin
                        sda_oe <= accept;
                        if (accept) begin
                            cnt <= CNT_ACK;
                        end else begin
                            cnt   <= '0;
                            phase <= PH_IDLE;
                        end
                    end else if (evt.fall && (cnt == CNT_ACK)) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        if (phase == PH_ADDR) begin
                            phase <= rx_sh[0] ? PH_TX : PH_RX;
                            if (rx_sh[0]) begin
                                scl_oe <= 1'b1;
                            end
                        end else if (stretch_en) begin
                            scl_oe <= 1'b1;
                        end
                    end
                end
                PH_TX: begin
                    if (evt.rise && (cnt < CNT_FULL)) begin
                        cnt <= cnt + 1'b1;
                    end else if (evt.fall && (cnt != '0) && (cnt < CNT_FULL)) begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_W-2];
                    end else if (evt.fall && (cnt == CNT_FULL)) begin
                        sda_oe <= 1'b0;
                        cnt    <= CNT_ACK;
                    end else if (evt.rise && (cnt == CNT_ACK)) begin
                        mack <= ~sda_s;
                    end else if (tx_end) begin
                        cnt <= '0;
                        if (mack) begin
                            scl_oe <= 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    hold_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_s);

    // R8
    sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R10
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!sda_oe && !scl_oe));
endmodule

// File: rtl/i2c_tgt_regs.sv
`timescale 1ns/1ps
// i2c_tgt_regs: the byte buffer and the status/interrupt flags seen by
// the local controller. Engine-side set requests win over clears that
// arrive in the same cycle.
// Assumes the engine never loads a byte while the buffer is full.
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ovf_set,
    input  logic              irq_set,
    input  logic              dir_set,
    input  logic              dir_clr,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] buf_rdata,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              dir_read
);
    // Buffer contents: received byte or controller-written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_rdata <= '0;
        end else if (rx_load) begin
            buf_rdata <= rx_byte;
        end else if (buf_wr) begin
            buf_rdata <= buf_wdata;
        end
    end

    // Status and interrupt flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            ovf      <= 1'b0;
            irq      <= 1'b0;
            dir_read <= 1'b0;
        end else begin
            if (rx_load)      buf_full <= 1'b1;
            else if (buf_rd)  buf_full <= 1'b0;
            if (ovf_set)      ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
            if (irq_set)      irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
            if (dir_set)      dir_read <= 1'b1;
            else if (dir_clr) dir_read <= 1'b0;
        end
    end

    // R4
    no_load_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |-> (!buf_full && !ovf));

    // R4
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(buf_full));

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_clr));

    // R5
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full) |-> $past(buf_rd));
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
// i2c_tgt_engine: I2C target with a 7-bit address, single byte buffer,
// per-byte interrupt and SCL stretching. Joins the pin synchronizer,
// the protocol engine and the register side.
// Assumes open-drain pads: a 1 on an *_oe output pulls the line low.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h2A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              stretch_en,
    input  logic              clk_release,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [BYTE_W-1:0] buf_rdata,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic              irq,
    output logic              buf_full,
    output logic              ovf,
    output logic              dir_read
);
    logic              scl_s;
    logic              sda_s;
    bus_evt_t          evt;
    logic              rx_load;
    logic [BYTE_W-1:0] rx_byte;
    logic              ovf_set;
    logic              irq_set;
    logic              dir_set;
    logic              dir_clr;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt)
    );

    i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .evt         (evt),
        .stretch_en  (stretch_en),
        .clk_release (clk_release),
        .buf_wr      (buf_wr),
        .buf_wdata   (buf_wdata),
        .buf_full    (buf_full),
        .ovf_flag    (ovf),
        .sda_oe      (sda_oe),
        .scl_oe      (scl_oe),
        .rx_load     (rx_load),
        .rx_byte     (rx_byte),
        .ovf_set     (ovf_set),
        .irq_set     (irq_set),
        .dir_set     (dir_set),
        .dir_clr     (dir_clr)
    );

    i2c_tgt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .ovf_set   (ovf_set),
        .irq_set   (irq_set),
        .dir_set   (dir_set),
        .dir_clr   (dir_clr),
        .buf_wr    (buf_wr),
        .buf_wdata (buf_wdata),
        .buf_rd    (buf_rd),
        .irq_clr   (irq_clr),
        .ovf_clr   (ovf_clr),
        .buf_rdata (buf_rdata),
        .buf_full  (buf_full),
        .ovf       (ovf),
        .irq       (irq),
        .dir_read  (dir_read)
    );
endmodule

// File: tb/tb_i2c_tgt_engine.sv
`timescale 1ns/1ps
// tb_i2c_tgt_engine: bus-master model with wired-AND lines, a vector
// table of write transactions, then directed tests.
module tb_i2c_tgt_engine;
    localparam logic [6:0] DEV = 7'h5C;
    localparam int         Q   = 8;
    localparam logic [7:0] AW  = {DEV, 1'b0};
    localparam logic [7:0] AR  = {DEV, 1'b1};

    // {expected address ACK, address byte, data byte}
    localparam logic [16:0] VEC [5] = '{
        {1'b1, 8'hB8, 8'h3C},
        {1'b1, 8'hB8, 8'h00},
        {1'b0, 8'h54, 8'h12},
        {1'b1, 8'hB8, 8'hFF},
        {1'b0, 8'hBC, 8'h81}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_line, sda_line;
    logic       scl_oe, sda_oe;
    logic       stretch_en = 1'b0, clk_release = 1'b0;
    logic       buf_wr = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic [7:0] buf_rdata;
    logic       irq, buf_full, ovf, dir_read;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_tgt_engine #(.DEV_ADDR(DEV), .SYNC_STAGES(3)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .stretch_en(stretch_en),
        .clk_release(clk_release), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rd(buf_rd), .buf_rdata(buf_rdata), .irq_clr(irq_clr),
        .ovf_clr(ovf_clr), .irq(irq), .buf_full(buf_full), .ovf(ovf),
        .dir_read(dir_read)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        tick(1);
        while (!scl_line) tick(1);
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = !b;
        tick(Q);
        scl_up();
        tick(Q);
        m_scl_low = 1'b1;
        tick(Q);
    endtask

    task automatic get_bit(output logic b, output logic steady);
        m_sda_low = 1'b0;
        tick(Q);
        scl_up();
        tick(Q / 2);
        b = sda_line;
        tick(Q / 2);
        steady = (sda_line == b);
        m_scl_low = 1'b1;
        tick(Q);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b1;
        tick(Q);
        m_scl_low = 1'b1;
        tick(Q);
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0;
        tick(Q);
        scl_up();
        tick(Q);
        m_sda_low = 1'b1;
        tick(Q);
        m_scl_low = 1'b1;
        tick(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        tick(Q);
        scl_up();
        tick(Q);
        m_sda_low = 1'b0;
        tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b, s;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(b, s);
        ack = !b;
    endtask

    task automatic read_byte(output logic [7:0] d, output logic steady, input logic give_ack);
        logic b, s;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, s);
            d[i] = b;
            steady = steady && s;
        end
        send_bit(!give_ack);
        m_sda_low = 1'b0;
    endtask

    task automatic pulse_rd();
        buf_rd = 1'b1; tick(1); buf_rd = 1'b0; tick(1);
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
    endtask

    task automatic pulse_ovf_clr();
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(1);
    endtask

    task automatic pulse_release();
        clk_release = 1'b1; tick(1); clk_release = 1'b0; tick(1);
    endtask

    task automatic load_tx(input logic [7:0] d);
        buf_wdata = d; buf_wr = 1'b1; tick(1); buf_wr = 1'b0; tick(1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       ack;
        logic       steady;
        logic [7:0] d;
        logic [7:0] last_buf;

        tick(5);
        // R1: reset state
        check("R1 scl_oe", scl_oe, 0);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 irq", irq, 0);
        check("R1 buf_full", buf_full, 0);
        check("R1 ovf", ovf, 0);
        check("R1 dir_read", dir_read, 0);
        check("R1 buf_rdata", buf_rdata, 0);
        rst_n = 1'b1;
        tick(4);
        last_buf = 8'h00;

        // R2 / R3: table of write transactions
        for (int i = 0; i < 5; i++) begin
            bus_start();
            write_byte(VEC[i][15:8], ack);
            if (VEC[i][16]) begin
                check("R2 address ack", ack, 1);
                check("R2 address in buffer", buf_rdata, VEC[i][15:8]);
                check("R2 dir_read write", dir_read, 0);
                check("R5 irq on address", irq, 1);
                tick(4);
                check("R6 no stretch on write address", scl_oe, 0);
                pulse_rd();
                pulse_irq_clr();
                write_byte(VEC[i][7:0], ack);
                check("R2 data ack", ack, 1);
                check("R2 data in buffer", buf_rdata, VEC[i][7:0]);
                last_buf = VEC[i][7:0];
                pulse_rd();
                pulse_irq_clr();
            end else begin
                check("R3 no ack on mismatch", ack, 0);
                check("R3 no irq on mismatch", irq, 0);
                write_byte(VEC[i][7:0], ack);
                check("R3 data ignored ack", ack, 0);
                check("R3 buffer kept", buf_rdata, last_buf);
            end
            bus_stop();
        end

        // R5: flags persist until cleared
        bus_start();
        write_byte(AW, ack);
        tick(40);
        check("R5 irq persists", irq, 1);
        check("R5 buf_full persists", buf_full, 1);
        pulse_irq_clr();
        check("R5 irq cleared", irq, 0);
        pulse_rd();
        check("R5 buf_full cleared", buf_full, 0);
        bus_stop();

        // R6: stretch after received data byte
        stretch_en = 1'b1;
        bus_start();
        write_byte(AW, ack);
        tick(4);
        check("R6 address not stretched", scl_oe, 0);
        pulse_rd();
        pulse_irq_clr();
        write_byte(8'h5A, ack);
        tick(4);
        check("R6 hold after data", scl_oe, 1);
        tick(20);
        check("R6 hold persists", scl_oe, 1);
        pulse_rd();
        pulse_irq_clr();
        pulse_release();
        check("R6 released", scl_oe, 0);
        bus_stop();
        stretch_en = 1'b0;

        // R4: overflow and blocking
        bus_start();
        write_byte(AW, ack);
        pulse_rd();
        pulse_irq_clr();
        write_byte(8'h11, ack);
        check("R4 first data ack", ack, 1);
        write_byte(8'h22, ack);
        check("R4 refused when full", ack, 0);
        check("R4 ovf set", ovf, 1);
        check("R4 buffer kept", buf_rdata, 8'h11);
        bus_stop();
        pulse_rd();
        pulse_irq_clr();
        bus_start();
        write_byte(AW, ack);
        check("R4 refused while ovf", ack, 0);
        bus_stop();
        pulse_ovf_clr();
        check("R4 ovf cleared", ovf, 0);
        bus_start();
        write_byte(AW, ack);
        check("R4 accepted after clear", ack, 1);
        bus_stop();
        pulse_rd();
        pulse_irq_clr();

        // R7 / R8 / R9: master read
        bus_start();
        write_byte(AR, ack);
        check("R7 read address ack", ack, 1);
        check("R7 dir_read set", dir_read, 1);
        check("R7 address in buffer", buf_rdata, AR);
        tick(4);
        check("R7 hold after read address", scl_oe, 1);
        pulse_rd();
        pulse_irq_clr();
        load_tx(8'hA5);
        pulse_release();
        read_byte(d, steady, 1'b1);
        check("R8 first byte", d, 8'hA5);
        check("R8 sda steady while scl high", steady, 1);
        check("R9 irq after master ack", irq, 1);
        check("R9 hold after master ack", scl_oe, 1);
        pulse_irq_clr();
        load_tx(8'h3C);
        pulse_release();
        read_byte(d, steady, 1'b0);
        check("R8 second byte", d, 8'h3C);
        check("R8 sda steady second", steady, 1);
        check("R9 irq after nack", irq, 1);
        check("R9 released after nack", scl_oe, 0);
        check("R9 dir cleared after nack", dir_read, 0);
        pulse_irq_clr();
        write_byte(AW, ack);
        check("R9 idle until start", ack, 0);
        bus_stop();

        // R10: repeated START and STOP abort
        bus_start();
        write_byte(AW, ack);
        pulse_rd();
        pulse_irq_clr();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        bus_rstart();
        write_byte(AW, ack);
        check("R10 address after repeated start", ack, 1);
        check("R10 buffer holds new address", buf_rdata, AW);
        pulse_rd();
        pulse_irq_clr();
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        check("R10 sda released", sda_oe, 0);
        check("R10 scl released", scl_oe, 0);
        m_scl_low = 1'b1;
        tick(Q);
        write_byte(AW, ack);
        check("R10 ignored after stop", ack, 0);
        bus_stop();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule